// File: doc/BRIEF.md
# Interval Timer Register Port

This block is the byte-wide host interface of a three-channel interval timer. A 2-bit address picks one of the three channel data ports (0, 1, 2) or the control port (3). Write and read strobes move one byte per cycle over an 8-bit data bus. The counting channels are outside this block. Each one supplies its live 16-bit count and its output level, and takes back a load strobe with a 16-bit start value, plus its mode and BCD setting.

Control writes program each channel's byte access mode, operating mode and BCD flag. They can also freeze a channel's count for a later read, or use the multi-channel read-back form to freeze count and/or status on several channels at once. Data-port writes are put together into 16-bit start values according to the access mode. Data-port reads return a pending status byte first, then a pending frozen count, and only then the live count. Reads and writes each keep their own low/high byte sequence.

Top module: `timer_port_ctl`

## Requirements
- R1: After reset, rdata is 0 and no load strobe is active. Every channel is in low-byte-only access with mode 0 and BCD 0.
- R2: A control write (address 3) with bits 7:6 = n (n < 3) and a nonzero access field in bits 5:4 does four things on channel n: it sets the access mode from bits 5:4, sets the mode from bits 3:1 and BCD from bit 0, and restarts both byte sequencers at the low byte. The new mode and BCD values appear on ch_mode[3n+2:3n] and ch_bcd[n] in the next cycle.
- R3: In access mode 1 (low byte only), a data write of byte b to channel n pulses load_stb[n] for one cycle, starting the cycle after the write, with load_val = {8'h00, b}. In access mode 2 (high byte only), the value is {b, 8'h00}.
- R4: In access mode 3 (word), the first data write is held and produces no load. The second write loads {second, first}.
- R5: At most one load strobe is active in any cycle. A load strobe only follows a data-port write.
- R6: A control write with access field 0 freezes channel n's live count. Later reads of that channel return the frozen count: the low byte for access mode 1, the high byte for access mode 2, or the low byte then the high byte for access mode 3. After that, reads return the live count.
- R7: A count freeze request is ignored while an earlier frozen count is still unread. The same holds for a status freeze request while an earlier status byte is still unread.
- R8: A control write with bits 7:6 = 3 is a read-back command. Bit n+1 selects channel n. Bit 5 = 0 freezes the count and bit 4 = 0 freezes the status of every selected channel.
- R9: The frozen status byte is {out, 0, access[1:0], mode[2:0], bcd}. A read returns it, and clears it, before any frozen count.
- R10: With nothing frozen, live reads in access mode 3 alternate between the low byte and the high byte. This read order is independent of the write byte order.
- R11: rdata changes only in the cycle after a read strobe and holds otherwise. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | 0 to 2 channel data port, 3 control port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data |
| live_cnt | input | 48 | Live count of each channel, channel n in bits 16n+15:16n |
| cnt_out | input | 3 | Output level of each channel |
| load_stb | output | 3 | One-cycle start value strobe per channel |
| load_val | output | 48 | Start value per channel, channel n in bits 16n+15:16n |
| ch_mode | output | 9 | Operating mode per channel, 3 bits each |
| ch_bcd | output | 3 | BCD flag per channel |

## Verification
Most internal faults show up as a wrong byte on rdata in the cycle after the next read of the affected channel. This includes a stuck byte-order flag, a frozen-count state that is never released, and a status byte that is not cleared. Write-side faults appear as a missing, early or misassembled load_val one cycle after the second write of a word. A bad control decode shows up on ch_mode or ch_bcd in the cycle right after the control write. The bench's reference model compares all of these ports on every clock, so the first divergent cycle is reported.

// File: rtl/timer_port_pkg.sv
package timer_port_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  localparam logic [1:0] CTRL_ADDR = 2'd3;
  localparam logic [1:0] RB_SEL    = 2'd3;
endpackage

// File: rtl/tp_decode.sv
module tp_decode
  import timer_port_pkg::*;
#(
  parameter int NCH = 3,
  parameter int BW  = 8
) (
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [BW-1:0] wdata,
  output logic [NCH-1:0] cw_stb,
  output logic [NCH-1:0] cnt_req,
  output logic [NCH-1:0] sts_req,
  output logic [NCH-1:0] dat_stb
);
  logic [1:0] sel;
  assign sel = wdata[7:6];

  always_comb begin
    cw_stb  = '0;
    cnt_req = '0;
    sts_req = '0;
    dat_stb = '0;
    if (wr_en && addr == CTRL_ADDR) begin
      for (int n = 0; n < NCH; n++) begin
        if (sel == RB_SEL) begin
          if (wdata[n+1]) begin
            cnt_req[n] = ~wdata[5];
            sts_req[n] = ~wdata[4];
          end
        end else if (sel == 2'(n)) begin
          if (wdata[5:4] == ACC_NONE) cnt_req[n] = 1'b1;
          else                        cw_stb[n]  = 1'b1;
        end
      end
    end else if (wr_en) begin
      for (int n = 0; n < NCH; n++)
        dat_stb[n] = (addr == 2'(n));
    end
  end
endmodule

// File: rtl/tp_channel.sv
module tp_channel
  import timer_port_pkg::*;
#(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cw_stb,
  input  acc_e          cw_acc,
  input  logic [2:0]    cw_mode,
  input  logic          cw_bcd,
  input  logic          cnt_req,
  input  logic          sts_req,
  input  logic          dat_stb,
  input  logic [BW-1:0] dat_byte,
  input  logic          rd_stb,
  input  logic [CW-1:0] live_cnt,
  input  logic          out_lvl,
  output logic [BW-1:0] rd_byte,
  output logic          ld_stb,
  output logic [CW-1:0] ld_val,
  output logic [2:0]    mode_q,
  output logic          bcd_q
);
  acc_e          acc_q, acc_n;
  acc_e          clat_q, clat_n;
  logic [2:0]    mode_n;
  logic          bcd_n;
  logic          wr_hi_q, wr_hi_n, rd_hi_q, rd_hi_n;
  logic          slat_q, slat_n;
  logic [BW-1:0] hold_q, hold_n, sts_q, sts_n;
  logic [CW-1:0] lcnt_q, lcnt_n, ld_val_n;
  logic          ld_stb_n;

  always_comb begin
    acc_n    = acc_q;
    mode_n   = mode_q;
    bcd_n    = bcd_q;
    wr_hi_n  = wr_hi_q;
    rd_hi_n  = rd_hi_q;
    clat_n   = clat_q;
    lcnt_n   = lcnt_q;
    slat_n   = slat_q;
    sts_n    = sts_q;
    hold_n   = hold_q;
    ld_stb_n = 1'b0;
    ld_val_n = ld_val;
    if (cw_stb) begin
      acc_n   = cw_acc;
      mode_n  = cw_mode;
      bcd_n   = cw_bcd;
      wr_hi_n = 1'b0;
      rd_hi_n = 1'b0;
    end
    if (cnt_req && clat_q == ACC_NONE) begin
      clat_n = acc_q;
      lcnt_n = live_cnt;
    end
    if (sts_req && !slat_q) begin
      slat_n = 1'b1;
      sts_n  = {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
    end
    if (dat_stb) begin
      unique case (acc_q)
        ACC_HI: begin
          ld_stb_n = 1'b1;
          ld_val_n = {dat_byte, {BW{1'b0}}};
        end
        ACC_WORD: begin
          if (!wr_hi_q) begin
            hold_n  = dat_byte;
            wr_hi_n = 1'b1;
          end else begin
            ld_stb_n = 1'b1;
            ld_val_n = {dat_byte, hold_q};
            wr_hi_n  = 1'b0;
          end
        end
        default: begin
          ld_stb_n = 1'b1;
          ld_val_n = {{BW{1'b0}}, dat_byte};
        end
      endcase
    end
    if (rd_stb) begin
      if (slat_q)                     slat_n  = 1'b0;
      else if (clat_q == ACC_WORD)    clat_n  = ACC_HI;
      else if (clat_q != ACC_NONE)    clat_n  = ACC_NONE;
      else if (acc_q == ACC_WORD)     rd_hi_n = ~rd_hi_q;
    end
  end

  always_comb begin
    if (slat_q)                  rd_byte = sts_q;
    else if (clat_q == ACC_HI)   rd_byte = lcnt_q[CW-1:BW];
    else if (clat_q != ACC_NONE) rd_byte = lcnt_q[BW-1:0];
    else if (acc_q == ACC_HI || (acc_q == ACC_WORD && rd_hi_q))
                                 rd_byte = live_cnt[CW-1:BW];
    else                         rd_byte = live_cnt[BW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= ACC_LO;
      mode_q  <= '0;
      bcd_q   <= 1'b0;
      wr_hi_q <= 1'b0;
      rd_hi_q <= 1'b0;
      clat_q  <= ACC_NONE;
      lcnt_q  <= '0;
      slat_q  <= 1'b0;
      sts_q   <= '0;
      hold_q  <= '0;
      ld_stb  <= 1'b0;
      ld_val  <= '0;
    end else begin
      acc_q   <= acc_n;
      mode_q  <= mode_n;
      bcd_q   <= bcd_n;
      wr_hi_q <= wr_hi_n;
      rd_hi_q <= rd_hi_n;
      clat_q  <= clat_n;
      lcnt_q  <= lcnt_n;
      slat_q  <= slat_n;
      sts_q   <= sts_n;
      hold_q  <= hold_n;
      ld_stb  <= ld_stb_n;
      ld_val  <= ld_val_n;
    end
  end
endmodule

// File: rtl/timer_port_ctl.sv
module timer_port_ctl
  import timer_port_pkg::*;
#(
  parameter int NCH = 3,
  parameter int BW  = 8,
  localparam int CW = 2 * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BW-1:0]     wdata,
  output logic [BW-1:0]     rdata,
  input  logic [NCH*CW-1:0] live_cnt,
  input  logic [NCH-1:0]    cnt_out,
  output logic [NCH-1:0]    load_stb,
  output logic [NCH*CW-1:0] load_val,
  output logic [NCH*3-1:0]  ch_mode,
  output logic [NCH-1:0]    ch_bcd
);
  logic [NCH-1:0] cw_stb, cnt_req, sts_req, dat_stb, rd_stb;
  logic [BW-1:0]  ch_byte [NCH];
  logic [BW-1:0]  byte_sel, rdata_n;

  tp_decode #(.NCH(NCH), .BW(BW)) u_dec (
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .cw_stb  (cw_stb),
    .cnt_req (cnt_req),
    .sts_req (sts_req),
    .dat_stb (dat_stb)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign rd_stb[n] = rd_en && (addr == 2'(n));
    tp_channel #(.BW(BW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cw_stb   (cw_stb[n]),
      .cw_acc   (acc_e'(wdata[5:4])),
      .cw_mode  (wdata[3:1]),
      .cw_bcd   (wdata[0]),
      .cnt_req  (cnt_req[n]),
      .sts_req  (sts_req[n]),
      .dat_stb  (dat_stb[n]),
      .dat_byte (wdata),
      .rd_stb   (rd_stb[n]),
      .live_cnt (live_cnt[n*CW +: CW]),
      .out_lvl  (cnt_out[n]),
      .rd_byte  (ch_byte[n]),
      .ld_stb   (load_stb[n]),
      .ld_val   (load_val[n*CW +: CW]),
      .mode_q   (ch_mode[n*3 +: 3]),
      .bcd_q    (ch_bcd[n])
    );
  end

  always_comb begin
    byte_sel = '0;
    for (int n = 0; n < NCH; n++)
      if (addr == 2'(n)) byte_sel = ch_byte[n];
  end

  assign rdata_n = rd_en ? byte_sel : rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_n;
  end
endmodule

// File: rtl/tp_checks.sv
module tp_checks #(
  parameter int NCH = 3,
  parameter int BW  = 8,
  localparam int CW = 2 * BW
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [BW-1:0]     wdata,
  input logic [BW-1:0]     rdata,
  input logic [NCH-1:0]    load_stb,
  input logic [NCH*3-1:0]  ch_mode,
  input logic [NCH-1:0]    ch_bcd
);
  assert_single_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb));

  assert_load_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || addr == 2'd3) |=> (load_stb == '0));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  assert_ctrl_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |=> (rdata == '0));

  assert_cw_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata[7:6] == 2'd0 && wdata[5:4] != 2'd0)
      |=> (ch_mode[2:0] == $past(wdata[3:1]) && ch_bcd[0] == $past(wdata[0])));
endmodule

bind timer_port_ctl tp_checks #(.NCH(NCH), .BW(BW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .wdata    (wdata),
  .rdata    (rdata),
  .load_stb (load_stb),
  .ch_mode  (ch_mode),
  .ch_bcd   (ch_bcd)
);

// File: tb/sim_timer_port_ctl.sv
`timescale 1ns/1ps
module sim_timer_port_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] live [3];
  logic [2:0]  cnt_out = '0;
  logic [47:0] live_cnt;
  logic [2:0]  load_stb;
  logic [47:0] load_val;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  assign live_cnt = {live[2], live[1], live[0]};

  always #2 clk = ~clk;

  timer_port_ctl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .cnt_out(cnt_out),
    .load_stb(load_stb), .load_val(load_val), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  function automatic void check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endfunction

  // behavioural reference model
  int m_acc[3], m_md[3], m_bc[3], m_wrhi[3], m_rdhi[3], m_hold[3];
  int m_clat[3], m_lcnt[3], m_slat[3], m_sts[3];
  int e_rd, e_ld, e_val[3];

  function automatic void m_latch_cnt(int n);
    if (m_clat[n] == 0) begin m_clat[n] = m_acc[n]; m_lcnt[n] = live[n]; end
  endfunction
  function automatic void m_latch_sts(int n);
    if (m_slat[n] == 0) begin
      m_slat[n] = 1;
      m_sts[n] = (cnt_out[n] << 7) | (m_acc[n] << 4) | (m_md[n] << 1) | m_bc[n];
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 3; n++) begin
        m_acc[n] = 1; m_md[n] = 0; m_bc[n] = 0; m_wrhi[n] = 0; m_rdhi[n] = 0;
        m_hold[n] = 0; m_clat[n] = 0; m_lcnt[n] = 0; m_slat[n] = 0; m_sts[n] = 0;
        e_val[n] = 0;
      end
      e_rd = 0; e_ld = 0;
    end else begin
      int a, d, sel;
      a = addr; d = wdata; e_ld = 0;
      if (wr_en && a == 3) begin
        sel = d >> 6;
        if (sel == 3) begin
          for (int n = 0; n < 3; n++)
            if (d & (2 << n)) begin
              if (!(d & 'h20)) m_latch_cnt(n);
              if (!(d & 'h10)) m_latch_sts(n);
            end
        end else if (((d >> 4) & 3) == 0) m_latch_cnt(sel);
        else begin
          m_acc[sel] = (d >> 4) & 3; m_md[sel] = (d >> 1) & 7; m_bc[sel] = d & 1;
          m_wrhi[sel] = 0; m_rdhi[sel] = 0;
        end
      end else if (wr_en) begin
        if (m_acc[a] == 1) begin e_ld = 1 << a; e_val[a] = d; end
        else if (m_acc[a] == 2) begin e_ld = 1 << a; e_val[a] = d << 8; end
        else if (m_wrhi[a] == 0) begin m_hold[a] = d; m_wrhi[a] = 1; end
        else begin e_ld = 1 << a; e_val[a] = (d << 8) | m_hold[a]; m_wrhi[a] = 0; end
      end
      if (rd_en) begin
        if (a == 3) e_rd = 0;
        else if (m_slat[a]) begin e_rd = m_sts[a]; m_slat[a] = 0; end
        else if (m_clat[a] != 0) begin
          if (m_clat[a] == 2) begin e_rd = m_lcnt[a] >> 8; m_clat[a] = 0; end
          else if (m_clat[a] == 3) begin e_rd = m_lcnt[a] & 255; m_clat[a] = 2; end
          else begin e_rd = m_lcnt[a] & 255; m_clat[a] = 0; end
        end else if (m_acc[a] == 2 || (m_acc[a] == 3 && m_rdhi[a] == 1)) begin
          e_rd = live[a] >> 8; if (m_acc[a] == 3) m_rdhi[a] = 0;
        end else begin
          e_rd = live[a] & 255; if (m_acc[a] == 3) m_rdhi[a] = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R11 rdata vs model", rdata, e_rd);
      check("R5 load_stb vs model", load_stb, e_ld);
      for (int n = 0; n < 3; n++) begin
        if (e_ld[n]) check("R3 load_val vs model", load_val[n*16 +: 16], e_val[n]);
        check("R2 mode vs model", ch_mode[n*3 +: 3], m_md[n]);
        check("R2 bcd vs model", ch_bcd[n], m_bc[n]);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input logic [1:0] a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    live[0] = '0; live[1] = '0; live[2] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset rdata", rdata, 0);
    check("R1 reset load_stb", load_stb, 0);
    check("R1 reset mode", ch_mode, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: default low-byte-only access
    wr(2'd1, 8'h5A);
    check("R1 default low-byte load", load_val[31:16], 16'h005A);
    // R2 / R3
    wr(2'd3, 8'h15);
    check("R2 mode ch0", ch_mode[2:0], 2);
    check("R2 bcd ch0", ch_bcd[0], 1);
    wr(2'd0, 8'h34);
    check("R3 lsb load strobe", load_stb, 3'b001);
    check("R3 lsb load value", load_val[15:0], 16'h0034);
    wr(2'd3, 8'h60);
    wr(2'd1, 8'hAB);
    check("R3 msb load value", load_val[31:16], 16'hAB00);
    // R4
    wr(2'd3, 8'hB6);
    wr(2'd2, 8'h11);
    check("R4 first byte no load", load_stb, 0);
    wr(2'd2, 8'h22);
    check("R4 word load", load_val[47:32], 16'h2211);
    // R10
    live[2] = 16'hBEEF;
    rd(2'd2); check("R10 live low", rdata, 8'hEF);
    rd(2'd2); check("R10 live high", rdata, 8'hBE);
    rd(2'd2); check("R10 live low again", rdata, 8'hEF);
    wr(2'd2, 8'h55);
    rd(2'd2); check("R10 read order independent", rdata, 8'hBE);
    wr(2'd2, 8'h66);
    check("R10 write order independent", load_val[47:32], 16'h6655);
    // R6
    live[2] = 16'h1234;
    wr(2'd3, 8'h80);
    live[2] = 16'h5678;
    rd(2'd2); check("R6 latched low", rdata, 8'h34);
    rd(2'd2); check("R6 latched high", rdata, 8'h12);
    rd(2'd2); check("R6 back to live", rdata, 8'h78);
    // R7
    live[1] = 16'h4321;
    wr(2'd3, 8'h40);
    live[1] = 16'h2211;
    wr(2'd3, 8'h40);
    rd(2'd1); check("R7 second latch ignored", rdata, 8'h43);
    rd(2'd1); check("R7 live after latch", rdata, 8'h22);
    // R8 / R9
    cnt_out = 3'b101; live[0] = 16'h00AA; live[2] = 16'h0BCD;
    wr(2'd3, 8'hCA);
    cnt_out = 3'b000; live[0] = 16'h0000; live[2] = 16'h0000;
    rd(2'd0); check("R9 status first ch0", rdata, 8'h95);
    rd(2'd0); check("R8 readback count ch0", rdata, 8'hAA);
    rd(2'd2); check("R9 status ch2", rdata, 8'hB6);
    rd(2'd2); check("R8 readback count low ch2", rdata, 8'hCD);
    rd(2'd2); check("R8 readback count high ch2", rdata, 8'h0B);
    live[0] = 16'h77C3;
    wr(2'd3, 8'hE2);
    live[0] = 16'h0011;
    rd(2'd0); check("R8 status only", rdata, 8'h15);
    rd(2'd0); check("R8 count not latched", rdata, 8'h11);
    // R11
    repeat (3) @(negedge clk);
    check("R11 rdata holds", rdata, 8'h11);
    rd(2'd3); check("R11 control read zero", rdata, 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule